// File: doc/BRIEF.md
# Processor status flags register unit

This block keeps a 32-bit x86-style processor status word in a register and updates it once per clock. When an ALU operation retires, the block works out the arithmetic flags (carry, parity, auxiliary carry, zero, sign, overflow) from the two operands, the result, the raw adder carry-out, the operand size and the kind of operation. It can also load the whole word at once, as a flags pop from the stack does. On that load the identification bit and the interrupt-enable bit are protected. A single-step trap acknowledge clears the trap flag.

All updates are registered: a change shows on the outputs after the rising clock edge that samples the strobe. The packed word and each flag are outputs. Reserved bits always read as fixed values, whatever is loaded.

Top module: `flagword_unit`

## Requirements
- R1: After reset the packed word reads 32'h0000_0002.
- R2: Bit 1 of the word always reads 1. Bits 3, 5, 15, 19, 20 and 31:22 always read 0. A pop of 32'hFFFF_FFFF with the ID load enabled and cpl=0 (starting from IOPL=0) gives 32'h0027_7FD7. The writable bits sit at CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10, OF=11, IOPL=13:12, NT=14, RF=16, VM=17, AC=18 and ID=21.
- R3: On an arithmetic or logic update, `alu_size` picks the width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. SF takes the result bit at the top of that width. ZF is set only when the result bits within that width are all zero.
- R4: On an arithmetic or logic update, PF is set when `res[7:0]` holds an even number of ones, and cleared otherwise, whatever the size.
- R5: On an arithmetic update, AF is set when there is a carry out of bit 3 (addition) or a borrow into bit 3 (subtraction). This is bit 4 of opa^opb^res.
- R6: On an arithmetic update, CF equals `cout` for an addition and the inverse of `cout` for a subtraction. Here `cout` is the raw adder carry out of the top bit of the selected width, and the adder computes opa + ~opb + 1 for a subtraction.
- R7: On an arithmetic update, OF is set when exactly one of these holds: a carry or borrow into the sign bit, or a carry or borrow out of the top bit.
- R8: On a logic update (`alu_logic`=1), CF and OF are cleared, SF, ZF and PF are updated, and AF keeps its old value.
- R9: A pop changes the ID bit only when `id_en` is 1. Otherwise ID keeps its value. No other update changes ID.
- R10: A pop changes IF only when `cpl` is no greater than the IOPL held before the pop. Otherwise IF keeps its value. ALU updates do not change IF.
- R11: `trap_ack` clears TF in the same update, even when a pop in that cycle loads TF=1.
- R12: When a pop and an ALU update occur in the same cycle, the pop decides the word and the ALU update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | ALU update strobe |
| alu_sub | input | 1 | Operation is a subtraction |
| alu_logic | input | 1 | Operation is a logic operation |
| alu_size | input | 2 | Operand width: 0=8, 1=16, else 32 bits |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res | input | 32 | ALU result |
| cout | input | 1 | Raw adder carry out of the top bit of the selected width |
| pop_we | input | 1 | Full-word load strobe |
| pop_val | input | 32 | Word to load |
| cpl | input | 2 | Current privilege level |
| id_en | input | 1 | Allows the ID bit to change on a load |
| trap_ack | input | 1 | Single-step trap acknowledge; clears TF |
| flags | output | 32 | Packed status word |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| tf | output | 1 | Trap flag |
| if_f | output | 1 | Interrupt enable flag |
| df | output | 1 | Direction flag |
| of | output | 1 | Overflow flag |
| iopl | output | 2 | I/O privilege level |
| nt | output | 1 | Nested task flag |
| rf | output | 1 | Resume flag |
| vm | output | 1 | Virtual mode flag |
| ac | output | 1 | Alignment check flag |
| id | output | 1 | Identification flag |

## Verification
The bench loads all ones and all zeros to show that a design with a wrong writable mask lets a reserved bit leak or loses bit 1. It runs 8-bit and 16-bit operations whose results carry non-zero upper bits, which catch a zero or sign test that ignores the size. It runs subtractions, which a design that does not invert the raw carry would report with CF wrong. Pops are tried with a privilege above and then equal to the old IOPL, and with the ID enable low, so that a design that compares against the new IOPL, or ignores the gates, loads the wrong IF or ID. A pop is also combined with an ALU update and with a trap acknowledge, to expose a wrong priority order.

// File: rtl/flagword_unit.sv
module flagword_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alu_we,
  input  logic        alu_sub,
  input  logic        alu_logic,
  input  logic [1:0]  alu_size,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [31:0] res,
  input  logic        cout,
  input  logic        pop_we,
  input  logic [31:0] pop_val,
  input  logic [1:0]  cpl,
  input  logic        id_en,
  input  logic        trap_ack,
  output logic [31:0] flags,
  output logic        cf,
  output logic        pf,
  output logic        af,
  output logic        zf,
  output logic        sf,
  output logic        tf,
  output logic        if_f,
  output logic        df,
  output logic        of,
  output logic [1:0]  iopl,
  output logic        nt,
  output logic        rf,
  output logic        vm,
  output logic        ac,
  output logic        id
);
  localparam logic [31:0] WMASK = 32'h0027_7FD5;
  localparam logic [31:0] FIXED = 32'h0000_0002;

  logic [31:0] q, cv, aw, pw, nx;
  logic [4:0]  sidx;
  logic        zero_n, cf_n, of_n, af_n;

  assign cv = opa ^ opb ^ res;

  always_comb begin
    case (alu_size)
      2'd0:    begin sidx = 5'd7;  zero_n = (res[7:0] == 8'h00);    end
      2'd1:    begin sidx = 5'd15; zero_n = (res[15:0] == 16'h0000); end
      default: begin sidx = 5'd31; zero_n = (res == 32'h0);          end
    endcase
  end

  assign cf_n = alu_logic ? 1'b0 : (cout ^ alu_sub);
  assign of_n = alu_logic ? 1'b0 : (cv[sidx] ^ cf_n);
  assign af_n = alu_logic ? q[4] : cv[4];

  always_comb begin
    aw     = q;
    aw[0]  = cf_n;
    aw[2]  = ~^res[7:0];
    aw[4]  = af_n;
    aw[6]  = zero_n;
    aw[7]  = res[sidx];
    aw[11] = of_n;
  end

  always_comb begin
    pw     = pop_val;
    pw[21] = id_en ? pop_val[21] : q[21];
    pw[9]  = (cpl <= q[13:12]) ? pop_val[9] : q[9];
  end

  always_comb begin
    if (pop_we)      nx = pw;
    else if (alu_we) nx = aw;
    else             nx = q;
    if (trap_ack)    nx[8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= FIXED;
    else        q <= (nx & WMASK) | FIXED;
  end

  assign flags = q;
  assign cf    = q[0];
  assign pf    = q[2];
  assign af    = q[4];
  assign zf    = q[6];
  assign sf    = q[7];
  assign tf    = q[8];
  assign if_f  = q[9];
  assign df    = q[10];
  assign of    = q[11];
  assign iopl  = q[13:12];
  assign nt    = q[14];
  assign rf    = q[16];
  assign vm    = q[17];
  assign ac    = q[18];
  assign id    = q[21];
endmodule

// File: rtl/flagword_unit_chk.sv
module flagword_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        alu_we,
  input logic        alu_logic,
  input logic        pop_we,
  input logic [1:0]  cpl,
  input logic        id_en,
  input logic        trap_ack,
  input logic [31:0] flags
);
  AST_RSVD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (flags[1] && ((flags & 32'hFFD8_8028) == 32'h0))); // R2

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_we && id_en) |=> (flags[21] == $past(flags[21]))); // R9

  AST_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_we || (cpl > flags[13:12])) |=> (flags[9] == $past(flags[9]))); // R10

  AST_TF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ack |=> !flags[8]); // R11

  AST_LOGIC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && alu_logic && !pop_we) |=> (!flags[0] && !flags[11] && (flags[4] == $past(flags[4])))); // R8
endmodule

bind flagword_unit flagword_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_logic(alu_logic),
  .pop_we(pop_we), .cpl(cpl), .id_en(id_en), .trap_ack(trap_ack), .flags(flags)
);

// File: tb/flagword_unit_tb.sv
module flagword_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_we = 1'b0, alu_sub = 1'b0, alu_logic = 1'b0;
  logic [1:0]  alu_size = 2'd0;
  logic [31:0] opa = '0, opb = '0, res = '0;
  logic        cout = 1'b0;
  logic        pop_we = 1'b0;
  logic [31:0] pop_val = '0;
  logic [1:0]  cpl = 2'd0;
  logic        id_en = 1'b0;
  logic        trap_ack = 1'b0;
  logic [31:0] flags;
  logic        cf, pf, af, zf, sf, tf, if_f, df, of, nt, rf, vm, ac, id;
  logic [1:0]  iopl;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  flagword_unit u_dut (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_sub(alu_sub),
    .alu_logic(alu_logic), .alu_size(alu_size), .opa(opa), .opb(opb),
    .res(res), .cout(cout), .pop_we(pop_we), .pop_val(pop_val), .cpl(cpl),
    .id_en(id_en), .trap_ack(trap_ack), .flags(flags), .cf(cf), .pf(pf),
    .af(af), .zf(zf), .sf(sf), .tf(tf), .if_f(if_f), .df(df), .of(of),
    .iopl(iopl), .nt(nt), .rf(rf), .vm(vm), .ac(ac), .id(id)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e, fl;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      fl = 32'h2;
      fl[0] = cf; fl[2] = pf; fl[4] = af; fl[6] = zf; fl[7] = sf;
      fl[8] = tf; fl[9] = if_f; fl[10] = df; fl[11] = of; fl[13:12] = iopl;
      fl[14] = nt; fl[16] = rf; fl[17] = vm; fl[18] = ac; fl[21] = id;
      n_checks++;
      if (flags !== e || fl !== e) begin
        n_fail++;
        $display("FAIL %s: flags=%h bits=%h expected=%h", t, flags, fl, e);
      end
    end
  end

  task automatic idle();
    alu_we = 0; alu_sub = 0; alu_logic = 0; pop_we = 0; trap_ack = 0; id_en = 0;
  endtask

  task automatic push(input logic [31:0] e, input string t);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    idle();
  endtask

  task automatic pop(input logic [31:0] v, input logic [1:0] c, input logic ide,
                     input logic [31:0] e, input string t);
    idle(); pop_we = 1; pop_val = v; cpl = c; id_en = ide;
    push(e, t);
  endtask

  task automatic alu(input logic lg, input logic sb, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] r,
                     input logic co, input logic [31:0] e, input string t);
    idle(); alu_we = 1; alu_logic = lg; alu_sub = sb; alu_size = sz;
    opa = a; opb = b; res = r; cout = co;
    push(e, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(32'h0000_0002); tag_q.push_back("R1 reset value");
    @(negedge clk);
    pop(32'hFFFF_FFFF, 2'd0, 1'b1, 32'h0027_7FD7, "R2 load all ones");
    pop(32'h0000_0000, 2'd3, 1'b0, 32'h0020_0002, "R9 ID held, R10 IF cleared");
    pop(32'h0000_0000, 2'd0, 1'b1, 32'h0000_0002, "R2 load all zeros");
    pop(32'h0020_0200, 2'd1, 1'b0, 32'h0000_0002, "R9 R10 both gated");
    pop(32'h0000_0200, 2'd0, 1'b0, 32'h0000_0202, "R10 IF set at cpl 0");
    pop(32'h0000_3000, 2'd3, 1'b0, 32'h0000_3202, "R10 IF kept, old IOPL 0");
    pop(32'h0000_0200, 2'd3, 1'b0, 32'h0000_0202, "R10 old IOPL 3 allows IF");
    alu(0, 0, 2'd0, 32'h7F, 32'h01, 32'h80, 1'b0, 32'h0000_0A92, "R7 R5 R3 8-bit add overflow");
    alu(0, 0, 2'd0, 32'hFF, 32'h01, 32'h100, 1'b1, 32'h0000_0257, "R3 R4 R6 8-bit wrap to zero");
    alu(0, 1, 2'd1, 32'h0, 32'h1, 32'hFFFF, 1'b0, 32'h0000_0297, "R6 16-bit borrow");
    alu(0, 1, 2'd2, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b1, 32'h0000_0A16, "R7 32-bit sub overflow");
    alu(0, 0, 2'd2, 32'h10, 32'h10, 32'h20, 1'b0, 32'h0000_0202, "R5 no nibble carry");
    alu(0, 0, 2'd0, 32'h0F, 32'h01, 32'h10, 1'b0, 32'h0000_0212, "R5 nibble carry");
    alu(1, 0, 2'd2, 32'h0, 32'h0, 32'h8000_0003, 1'b1, 32'h0000_0296, "R8 logic 32-bit");
    alu(1, 0, 2'd1, 32'h0, 32'h0, 32'h0001_0000, 1'b1, 32'h0000_0256, "R8 R3 logic 16-bit zero");
    idle(); pop_we = 1; pop_val = 32'h0000_0100; cpl = 2'd0;
    alu_we = 1; alu_logic = 0; alu_sub = 0; alu_size = 2'd0;
    opa = 32'hFF; opb = 32'h01; res = 32'h00; cout = 1'b1;
    push(32'h0000_0102, "R12 pop beats ALU");
    idle(); trap_ack = 1;
    push(32'h0000_0002, "R11 trap ack clears TF");
    idle(); trap_ack = 1; pop_we = 1; pop_val = 32'h0000_0100; cpl = 2'd0;
    push(32'h0000_0002, "R11 trap ack beats pop TF");
    idle();
    push(32'h0000_0002, "R12 idle keeps word");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule